// File: doc/BRIEF.md
# Space-Time Gray-Scale Dither Generator

This block turns a 4-bit intensity code into the single on/off drive bit for one pixel of a passive LCD. Each code stands for a fixed duty ratio. The block reaches that ratio by switching the pixel on in some frames and off in others. Pixels next to each other are phase-shifted, so that a flat area of one shade does not flash all at once. The phase comes from a frame counter plus an offset derived from the pixel's column and row.

One pixel is presented per valid cycle, with its code, column and row. A frame-start strobe advances the frame counter. The result appears one clock later with its own valid flag. A polarity input selects whether a high output means "pixel on" or "pixel off", which suits either kind of panel. For colour panels, three instances run side by side, one for each of red, green and blue.

Top module: `gray_dither`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `out_bit` is 0, and the frame count is 0.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high. `out_bit` in that cycle is the result for the pixel presented with it.
- R3: The frame count advances by one on each clock edge where `frame_start` is high, and wraps from 89 to 0. A pixel presented in the same cycle as `frame_start` uses the count as it was before the advance.
- R4: Each code selects a numerator N and a period P: 0→0/1, 1→1/9, 2→1/5, 3→4/15, 4→3/9, 5→2/5, 6→4/9, 7→1/2, 8→5/9, 9→3/5, 10→6/9, 11→11/15, 12→4/5, 13→8/9, 14→1/1, 15→1/1.
- R5: The pixel is on when (frame_count + column + 2·row) mod P < N.
- R6: Code 0 is never on. Codes 14 and 15 are always on, whatever the frame, column or row.
- R7: With `invert` high on the input cycle, `out_bit` is the complement of the on/off result.
- R8: For a fixed pixel and code, the number of on results over 90 consecutive frames equals 90·N/P exactly.
- R9: In a cycle after `in_valid` was low, `out_bit` keeps its previous value and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Advances the frame count |
| in_valid | input | 1 | A pixel is presented this cycle |
| code | input | 4 | Intensity code of the pixel |
| col | input | COL_W | Pixel column |
| row | input | ROW_W | Pixel row |
| invert | input | 1 | Inverts the sense of the output |
| out_bit | output | 1 | Modulated drive bit |
| out_valid | output | 1 | `out_bit` holds a new result |

## Verification
The hardest case to reach is the frame count at its wrap point, 89, in the same cycle that a pixel arrives together with a frame-start strobe. The wrap, the ordering of the advance and the pixel lookup all meet in that one cycle. The bench gets there by sending 89 lone frame-start strobes. It then presents a pixel with the strobe raised, followed by one without it, and checks both results against its own model of the phase. A 90-frame sweep for every code then confirms the exact on-count for each duty ratio.

// File: rtl/gray_dither.sv
module gray_dither #(
  parameter int COL_W = 10,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             in_valid,
  input  logic [3:0]       code,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic             invert,
  output logic             out_bit,
  output logic             out_valid
);
  localparam int FMOD = 90;
  localparam int FW   = $clog2(FMOD);
  localparam int MW   = (COL_W > ROW_W + 1) ? COL_W : ROW_W + 1;
  localparam int BW   = (MW > FW) ? MW : FW;
  localparam int SW   = BW + 2;

  logic [FW-1:0] fcnt;
  logic [3:0]    num, per, phase;
  logic [SW-1:0] sum;
  logic          on;

  always_comb begin
    case (code)
      4'd0:    begin num = 4'd0;  per = 4'd1;  end
      4'd1:    begin num = 4'd1;  per = 4'd9;  end
      4'd2:    begin num = 4'd1;  per = 4'd5;  end
      4'd3:    begin num = 4'd4;  per = 4'd15; end
      4'd4:    begin num = 4'd3;  per = 4'd9;  end
      4'd5:    begin num = 4'd2;  per = 4'd5;  end
      4'd6:    begin num = 4'd4;  per = 4'd9;  end
      4'd7:    begin num = 4'd1;  per = 4'd2;  end
      4'd8:    begin num = 4'd5;  per = 4'd9;  end
      4'd9:    begin num = 4'd3;  per = 4'd5;  end
      4'd10:   begin num = 4'd6;  per = 4'd9;  end
      4'd11:   begin num = 4'd11; per = 4'd15; end
      4'd12:   begin num = 4'd4;  per = 4'd5;  end
      4'd13:   begin num = 4'd8;  per = 4'd9;  end
      default: begin num = 4'd1;  per = 4'd1;  end
    endcase
  end

  assign sum = SW'(fcnt) + SW'(col) + {SW'(row), 1'b0} >> 0;

  always_comb begin
    case (per)
      4'd9:    phase = 4'(sum % SW'(9));
      4'd5:    phase = 4'(sum % SW'(5));
      4'd15:   phase = 4'(sum % SW'(15));
      4'd2:    phase = 4'(sum % SW'(2));
      default: phase = 4'd0;
    endcase
  end

  assign on = phase < num;

  always_ff @(posedge clk) begin
    if (rst) fcnt <= '0;
    else if (frame_start) fcnt <= (fcnt == FW'(FMOD - 1)) ? '0 : fcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bit <= on ^ invert;
    end
  end

  assert_fcnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    fcnt < FW'(FMOD));
  assert_fcnt_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    frame_start && fcnt == FW'(FMOD - 1) |=> fcnt == '0);
  assert_fcnt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(fcnt));
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_bit));
  assert_dark_code_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && code == 4'd0 |=> out_bit == $past(invert));
  assert_full_code_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && code >= 4'd14 |=> out_bit == !$past(invert));
endmodule

// File: tb/sim_gray_dither.sv
`timescale 1ns/1ps
module sim_gray_dither;
  logic clk = 0, rst = 1, frame_start = 0, in_valid = 0, invert = 0;
  logic [3:0] code = 0;
  logic [9:0] col = 0;
  logic [8:0] row = 0;
  logic out_bit, out_valid;
  int errors = 0, checks = 0, mfc = 0;

  always #10 clk = ~clk;

  gray_dither u0 (.clk, .rst, .frame_start, .in_valid, .code, .col, .row,
                  .invert, .out_bit, .out_valid);

  // {invert, code, col[3:0], row[3:0], expected} with frame count 0 (R4, R5, R7)
  localparam logic [13:0] VEC [14] = '{
    {1'b0, 4'd1,  4'd0, 4'd0, 1'b1},
    {1'b0, 4'd1,  4'd1, 4'd0, 1'b0},
    {1'b0, 4'd3,  4'd3, 4'd0, 1'b1},
    {1'b0, 4'd3,  4'd2, 4'd1, 1'b0},
    {1'b1, 4'd7,  4'd1, 4'd0, 1'b1},
    {1'b0, 4'd7,  4'd2, 4'd3, 1'b1},
    {1'b0, 4'd9,  4'd4, 4'd1, 1'b1},
    {1'b1, 4'd9,  4'd3, 4'd0, 1'b1},
    {1'b0, 4'd13, 4'd8, 4'd0, 1'b0},
    {1'b0, 4'd11, 4'd5, 4'd5, 1'b1},
    {1'b1, 4'd14, 4'd3, 4'd2, 1'b0},
    {1'b0, 4'd0,  4'd0, 4'd0, 1'b0},
    {1'b0, 4'd6,  4'd1, 4'd1, 1'b1},
    {1'b0, 4'd12, 4'd4, 4'd0, 1'b0}
  };

  function automatic void ratio(input int c, output int n, output int p);
    case (c)
      0: begin n = 0; p = 1; end   1: begin n = 1; p = 9; end
      2: begin n = 1; p = 5; end   3: begin n = 4; p = 15; end
      4: begin n = 3; p = 9; end   5: begin n = 2; p = 5; end
      6: begin n = 4; p = 9; end   7: begin n = 1; p = 2; end
      8: begin n = 5; p = 9; end   9: begin n = 3; p = 5; end
      10: begin n = 6; p = 9; end  11: begin n = 11; p = 15; end
      12: begin n = 4; p = 5; end  13: begin n = 8; p = 9; end
      default: begin n = 1; p = 1; end
    endcase
  endfunction

  function automatic logic model(input int c, input int x, input int y, input int f);
    int n, p;
    ratio(c, n, p);
    return ((f + x + 2 * y) % p) < n;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pixel(input int c, input int x, input int y, input logic inv, input logic fs);
    @(negedge clk);
    in_valid = 1; code = 4'(c); col = 10'(x); row = 9'(y); invert = inv; frame_start = fs;
    @(negedge clk);
    in_valid = 0; frame_start = 0;
    if (fs) mfc = (mfc + 1) % 90;
  endtask

  task automatic tick_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    mfc = (mfc + 1) % 90;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_bit == 0, "R1 reset outputs", {out_valid, out_bit}, 0);
    rst = 0;
    pixel(1, 0, 0, 0, 0);
    chk(out_bit == 1, "R1 frame count zero after reset", out_bit, 1);
    chk(out_valid == 1, "R2 valid one cycle later", out_valid, 1);

    foreach (VEC[i]) begin
      pixel(int'(VEC[i][12:9]), int'(VEC[i][8:5]), int'(VEC[i][4:1]), VEC[i][13], 0);
      chk(out_bit == VEC[i][0], $sformatf("R5 vector %0d", i), out_bit, VEC[i][0]);
    end

    pixel(13, 0, 0, 0, 0);
    @(negedge clk);
    chk(out_valid == 0, "R9 valid drops when idle", out_valid, 0);
    code = 4'd0; invert = 1; col = 10'd1;
    @(negedge clk);
    chk(out_bit == 1 && out_valid == 0, "R9 output holds when idle", out_bit, 1);
    invert = 0;

    for (int c = 0; c < 16; c++) begin
      int n, p, cnt, bad;
      ratio(c, n, p);
      cnt = 0; bad = 0;
      for (int f = 0; f < 90; f++) begin
        pixel(c, c * 3, c, 0, 0);
        if (out_bit !== model(c, c * 3, c, mfc)) bad++;
        if (out_bit) cnt++;
        tick_frame();
      end
      chk(bad == 0, $sformatf("R4 per-frame phase code %0d", c), bad, 0);
      chk(cnt == 90 * n / p, $sformatf("R8 on count code %0d", c), cnt, 90 * n / p);
      if (c == 0 || c >= 14)
        chk(cnt == (c == 0 ? 0 : 90), $sformatf("R6 fixed code %0d", c), cnt, c == 0 ? 0 : 90);
    end

    for (int k = 0; k < 89; k++) tick_frame();
    pixel(1, 0, 0, 0, 1);
    chk(out_bit == 0, "R3 pixel with strobe at count 89", out_bit, 0);
    pixel(1, 0, 0, 0, 0);
    chk(out_bit == 1, "R3 count wrapped to 0", out_bit, 1);
    pixel(2, 2, 1, 1, 0);
    chk(out_bit == ~model(2, 2, 1, mfc), "R7 inverted result", out_bit, ~model(2, 2, 1, mfc));

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; mfc = 0;
    chk(out_valid == 0 && out_bit == 0, "R1 reset mid-run", {out_valid, out_bit}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule